// File: doc/BRIEF.md
# Dual-Mode Peripheral DMA Channel

This block is a single DMA channel. It copies data between a 32-bit local memory bus and a narrower module port, in either direction. Software loads a local address, a module address and a byte count through a small write port. It then writes a control word that picks the mode, the direction and the port width, and sets the go bit. While the transfer runs, the channel shows busy, done, error and the remaining byte count on status outputs.

The channel has two modes. In request mode the module raises a request level, and the channel serves one port-width transfer each time it finds that level high while idle. It acknowledges the module's I/O-space access while that access is on the port. In addressed mode no request is needed: the channel moves data to or from module memory space as soon as a legal go is written. Each transfer is one source read followed by one destination write, and both are exactly the port width. Data sits in the low-order byte lanes, with lane k belonging to address+k. The channel checks the programmed values when go is written. An illegal setup raises the error flag and the transfer never starts.

Top module: `pdma_chan`

## Requirements
- R1: In addressed mode (control bit 1 = 1), a legal go (control bit 0 = 1) sets busy on the next clock, and the first source request appears on the clock after that, whatever the request input is doing.
- R2: In request mode (control bit 1 = 0), an enabled channel starts a transfer only while `pt_dreq` is high. While `pt_dreq` stays low, neither bus is requested and the count does not change.
- R3: `pt_dack` is high only during a port access of an enabled channel in request mode. It stays low in addressed mode and after the channel has finished, even if `pt_dreq` stays high.
- R4: Control bits 4:3 select the port width: 0 is 8 bits, 1 is 16 bits, 2 is 32 bits, and 3 is illegal. Every port access carries that width code on `pt_size`, and the module address advances by 1, 2 or 4 bytes after each transfer. `pt_mem` is 1 in addressed mode and 0 in request mode.
- R5: The local address needs no alignment. Each local bus beat moves the port width (shown on `lb_size`), and the local address advances by exactly the number of bytes that beat moved.
- R6: Control bit 2 sets the direction: 0 copies local memory to the module, 1 copies the module to local memory. The bytes arrive unchanged and in address order.
- R7: The byte count drops by the width after each completed transfer. When it reaches zero, done is set and busy is cleared in the same clock.
- R8: A go is refused and error is set, with no bus activity, when the count is zero, the width code is 3, or the count is not a multiple of the width in bytes. A legal go clears error and done.
- R9: A go in request mode is refused with error set unless the module address register holds zero.
- R10: While busy, writes to the address, count and control registers are ignored.
- R11: After reset, busy, done and error are 0, the count reads 0, and neither bus is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 local address, 1 module address, 2 byte count, 3 control |
| reg_wdata | input | 32 | Register write data |
| st_busy | output | 1 | Channel enabled and running |
| st_done | output | 1 | Last transfer finished |
| st_err | output | 1 | Last go refused |
| st_count | output | 24 | Remaining byte count |
| lb_req | output | 1 | Local bus request, held until ack |
| lb_we | output | 1 | Local bus write (1) or read (0) |
| lb_addr | output | 32 | Local bus byte address |
| lb_size | output | 2 | Local beat width code (same coding as port width) |
| lb_wdata | output | 32 | Local write data, low lanes used |
| lb_rdata | input | 32 | Local read data |
| lb_ack | input | 1 | Local bus completion |
| pt_dreq | input | 1 | Module DMA request level |
| pt_dack | output | 1 | Acknowledge to the module |
| pt_req | output | 1 | Port access request, held until ack |
| pt_we | output | 1 | Port write (1) or read (0) |
| pt_mem | output | 1 | Port space: 1 memory, 0 I/O |
| pt_addr | output | 24 | Module address |
| pt_size | output | 2 | Port access width code |
| pt_wdata | output | 32 | Port write data, low lanes used |
| pt_rdata | input | 32 | Port read data |
| pt_ack | input | 1 | Port completion |

## Verification
The hardest state to reach is a request-mode channel that is enabled but idle, with the request line low. Only in that state can the bench show that the channel is truly gated by the request and that register writes do nothing while it is busy. The stimulus programs a legal request-mode transfer and holds `pt_dreq` low. It then tries to overwrite the count and reads the count back from the status outputs. Only after that does it raise the request. It keeps the request high after completion to show the acknowledge never returns. Unaligned local addresses in both directions exercise the address stepping.

// File: rtl/pdma_pkg.sv
package pdma_pkg;

  typedef enum logic [1:0] {
    PW_8   = 2'd0,
    PW_16  = 2'd1,
    PW_32  = 2'd2,
    PW_BAD = 2'd3
  } pw_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_SRC  = 2'd1,
    SQ_DST  = 2'd2
  } sq_e;

  typedef struct packed {
    logic addressed;
    logic to_local;
    pw_e  width;
  } ctl_t;

  localparam logic [1:0] SEL_LADDR = 2'd0;
  localparam logic [1:0] SEL_MADDR = 2'd1;
  localparam logic [1:0] SEL_COUNT = 2'd2;
  localparam logic [1:0] SEL_CTRL  = 2'd3;

  function automatic logic [2:0] pw_bytes(input pw_e w);
    case (w)
      PW_8:    pw_bytes = 3'd1;
      PW_16:   pw_bytes = 3'd2;
      PW_32:   pw_bytes = 3'd4;
      default: pw_bytes = 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/pdma_regs.sv
module pdma_regs
  import pdma_pkg::*;
#(
  parameter int LA_W  = 32,
  parameter int MA_W  = 24,
  parameter int CNT_W = 24,
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [1:0]       sel,
  input  logic [REG_W-1:0] wdata,
  input  logic             step,
  output logic [LA_W-1:0]  la,
  output logic [MA_W-1:0]  ma,
  output logic [CNT_W-1:0] cnt,
  output ctl_t             ctl,
  output logic             busy,
  output logic             done,
  output logic             err
);

  logic [LA_W-1:0]  la_n;
  logic [MA_W-1:0]  ma_n;
  logic [CNT_W-1:0] cnt_n;
  ctl_t             ctl_n;
  logic             busy_n, done_n, err_n;
  logic [2:0]       cur_bytes, new_bytes;
  ctl_t             new_ctl;
  logic             go_legal;

  assign cur_bytes = pw_bytes(ctl.width);

  always_comb begin
    new_ctl.addressed = wdata[1];
    new_ctl.to_local  = wdata[2];
    new_ctl.width     = pw_e'(wdata[4:3]);
    new_bytes         = pw_bytes(new_ctl.width);
    go_legal = (new_ctl.width != PW_BAD) && (cnt != '0) &&
               ((cnt & CNT_W'(new_bytes - 3'd1)) == '0) &&
               (new_ctl.addressed || (ma == '0));
  end

  always_comb begin
    la_n   = la;
    ma_n   = ma;
    cnt_n  = cnt;
    ctl_n  = ctl;
    busy_n = busy;
    done_n = done;
    err_n  = err;
    if (step && busy) begin
      la_n  = la + LA_W'(cur_bytes);
      ma_n  = ma + MA_W'(cur_bytes);
      cnt_n = cnt - CNT_W'(cur_bytes);
      if (cnt == CNT_W'(cur_bytes)) begin
        busy_n = 1'b0;
        done_n = 1'b1;
      end
    end else if (wr && !busy) begin
      case (sel)
        SEL_LADDR: la_n  = LA_W'(wdata);
        SEL_MADDR: ma_n  = MA_W'(wdata);
        SEL_COUNT: cnt_n = CNT_W'(wdata);
        default: begin
          ctl_n = new_ctl;
          if (wdata[0]) begin
            done_n = 1'b0;
            if (go_legal) begin
              busy_n = 1'b1;
              err_n  = 1'b0;
            end else begin
              err_n  = 1'b1;
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      la   <= '0;
      ma   <= '0;
      cnt  <= '0;
      ctl  <= '0;
      busy <= 1'b0;
      done <= 1'b0;
      err  <= 1'b0;
    end else begin
      la   <= la_n;
      ma   <= ma_n;
      cnt  <= cnt_n;
      ctl  <= ctl_n;
      busy <= busy_n;
      done <= done_n;
      err  <= err_n;
    end
  end

endmodule

// File: rtl/pdma_seq.sv
module pdma_seq
  import pdma_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  logic addressed,
  input  logic to_local,
  input  logic dreq,
  input  logic lb_ack,
  input  logic pt_ack,
  output logic lb_req,
  output logic lb_we,
  output logic pt_req,
  output logic pt_we,
  output logic pt_dack,
  output logic cap,
  output logic step
);

  sq_e  st_q, st_n;
  logic src_ack, dst_ack;

  assign src_ack = to_local ? pt_ack : lb_ack;
  assign dst_ack = to_local ? lb_ack : pt_ack;

  always_comb begin
    st_n = st_q;
    cap  = 1'b0;
    step = 1'b0;
    case (st_q)
      SQ_IDLE: if (busy && (addressed || dreq)) st_n = SQ_SRC;
      SQ_SRC: if (src_ack) begin
        cap  = 1'b1;
        st_n = SQ_DST;
      end
      SQ_DST: if (dst_ack) begin
        step = 1'b1;
        st_n = SQ_IDLE;
      end
      default: st_n = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SQ_IDLE;
    else        st_q <= st_n;
  end

  assign lb_req  = ((st_q == SQ_SRC) && !to_local) || ((st_q == SQ_DST) && to_local);
  assign lb_we   = (st_q == SQ_DST) && to_local;
  assign pt_req  = ((st_q == SQ_SRC) && to_local) || ((st_q == SQ_DST) && !to_local);
  assign pt_we   = (st_q == SQ_DST) && !to_local;
  assign pt_dack = pt_req && !addressed && busy;

endmodule

// File: rtl/pdma_lane.sv
module pdma_lane
  import pdma_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap,
  input  pw_e               width,
  input  logic [DATA_W-1:0] src_data,
  output logic [DATA_W-1:0] buf_q
);

  localparam int LANES = DATA_W / 8;

  logic [DATA_W-1:0] masked;
  logic [2:0]        nbytes;

  assign nbytes = pw_bytes(width);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign masked[8*k +: 8] = (k < int'(nbytes)) ? src_data[8*k +: 8] : 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   buf_q <= '0;
    else if (cap) buf_q <= masked;
  end

endmodule

// File: rtl/pdma_chan.sv
module pdma_chan
  import pdma_pkg::*;
#(
  parameter int LA_W   = 32,
  parameter int MA_W   = 24,
  parameter int CNT_W  = 24,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_sel,
  input  logic [31:0]       reg_wdata,
  output logic              st_busy,
  output logic              st_done,
  output logic              st_err,
  output logic [CNT_W-1:0]  st_count,
  output logic              lb_req,
  output logic              lb_we,
  output logic [LA_W-1:0]   lb_addr,
  output logic [1:0]        lb_size,
  output logic [DATA_W-1:0] lb_wdata,
  input  logic [DATA_W-1:0] lb_rdata,
  input  logic              lb_ack,
  input  logic              pt_dreq,
  output logic              pt_dack,
  output logic              pt_req,
  output logic              pt_we,
  output logic              pt_mem,
  output logic [MA_W-1:0]   pt_addr,
  output logic [1:0]        pt_size,
  output logic [DATA_W-1:0] pt_wdata,
  input  logic [DATA_W-1:0] pt_rdata,
  input  logic              pt_ack
);

  ctl_t              ctl;
  logic              cap, step;
  logic [DATA_W-1:0] buf_q;

  pdma_regs #(
    .LA_W(LA_W), .MA_W(MA_W), .CNT_W(CNT_W), .REG_W(32)
  ) regs_i (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .sel(reg_sel), .wdata(reg_wdata),
    .step(step), .la(lb_addr), .ma(pt_addr), .cnt(st_count), .ctl(ctl),
    .busy(st_busy), .done(st_done), .err(st_err)
  );

  pdma_seq seq_i (
    .clk(clk), .rst_n(rst_n), .busy(st_busy), .addressed(ctl.addressed),
    .to_local(ctl.to_local), .dreq(pt_dreq), .lb_ack(lb_ack), .pt_ack(pt_ack),
    .lb_req(lb_req), .lb_we(lb_we), .pt_req(pt_req), .pt_we(pt_we),
    .pt_dack(pt_dack), .cap(cap), .step(step)
  );

  pdma_lane #(.DATA_W(DATA_W)) lane_i (
    .clk(clk), .rst_n(rst_n), .cap(cap), .width(ctl.width),
    .src_data(ctl.to_local ? pt_rdata : lb_rdata), .buf_q(buf_q)
  );

  assign lb_wdata = buf_q;
  assign pt_wdata = buf_q;
  assign lb_size  = ctl.width;
  assign pt_size  = ctl.width;
  assign pt_mem   = ctl.addressed;

endmodule

// File: rtl/pdma_chan_chk.sv
module pdma_chan_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        st_busy,
  input logic        st_done,
  input logic        st_err,
  input logic [23:0] st_count,
  input logic        lb_req,
  input logic        lb_ack,
  input logic [31:0] lb_addr,
  input logic        pt_req,
  input logic        pt_ack,
  input logic        pt_dack,
  input logic        pt_mem,
  input logic [23:0] pt_addr,
  input logic [1:0]  pt_size
);

  a_r3_dack_in_access: assert property (@(posedge clk) disable iff (!rst_n)
    pt_dack |-> (pt_req && st_busy && !pt_mem));

  a_r2_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !st_busy |-> (!lb_req && !pt_req));

  a_r2_one_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !(lb_req && pt_req));

  a_r8_err_never_busy: assert property (@(posedge clk) disable iff (!rst_n)
    st_err |-> !st_busy);

  a_r7_done_with_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_done) |-> (!st_busy && st_count == 24'd0));

  a_r4_port_held: assert property (@(posedge clk) disable iff (!rst_n)
    (pt_req && !pt_ack) |=> (pt_req && $stable(pt_addr) && $stable(pt_size)));

  a_r5_local_held: assert property (@(posedge clk) disable iff (!rst_n)
    (lb_req && !lb_ack) |=> (lb_req && $stable(lb_addr)));

endmodule

bind pdma_chan pdma_chan_chk chk_i (
  .clk(clk), .rst_n(rst_n), .st_busy(st_busy), .st_done(st_done), .st_err(st_err),
  .st_count(st_count), .lb_req(lb_req), .lb_ack(lb_ack), .lb_addr(lb_addr),
  .pt_req(pt_req), .pt_ack(pt_ack), .pt_dack(pt_dack), .pt_mem(pt_mem),
  .pt_addr(pt_addr), .pt_size(pt_size)
);

// File: tb/pdma_chan_tb_top.sv
`timescale 1ns/1ps
module pdma_chan_tb_top;

  logic        clk, rst_n;
  logic        reg_wr;
  logic [1:0]  reg_sel;
  logic [31:0] reg_wdata;
  logic        st_busy, st_done, st_err;
  logic [23:0] st_count;
  logic        lb_req, lb_we, lb_ack;
  logic [31:0] lb_addr, lb_wdata, lb_rdata;
  logic [1:0]  lb_size, pt_size;
  logic        pt_dreq, pt_dack, pt_req, pt_we, pt_mem, pt_ack;
  logic [23:0] pt_addr;
  logic [31:0] pt_wdata, pt_rdata;

  pdma_chan dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .st_busy(st_busy), .st_done(st_done), .st_err(st_err), .st_count(st_count),
    .lb_req(lb_req), .lb_we(lb_we), .lb_addr(lb_addr), .lb_size(lb_size),
    .lb_wdata(lb_wdata), .lb_rdata(lb_rdata), .lb_ack(lb_ack),
    .pt_dreq(pt_dreq), .pt_dack(pt_dack), .pt_req(pt_req), .pt_we(pt_we),
    .pt_mem(pt_mem), .pt_addr(pt_addr), .pt_size(pt_size), .pt_wdata(pt_wdata),
    .pt_rdata(pt_rdata), .pt_ack(pt_ack)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int n_chk, n_bad;
  logic [7:0] lmem [256];
  logic [7:0] pmem [256];
  logic [31:0] exp_la;
  logic [23:0] exp_ma;
  logic [1:0]  exp_pw;
  logic        exp_mem;
  int lb_acc, pt_acc, dack_cnt;

  task automatic check(input logic ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int nb(input logic [1:0] w);
    return (w == 2'd0) ? 1 : (w == 2'd1) ? 2 : 4;
  endfunction

  // bus responders, one-cycle latency, driven on the falling edge
  always @(negedge clk) begin
    if (pt_dack) dack_cnt++;
    if (lb_req && !lb_ack) begin
      logic [31:0] rd;
      rd = '0;
      lb_acc++;
      check(lb_addr == exp_la, "R5 local address", lb_addr, exp_la);
      check(lb_size == exp_pw, "R5 local beat size", lb_size, exp_pw);
      for (int i = 0; i < nb(lb_size); i++) begin
        if (lb_we) lmem[8'(lb_addr + i)] = lb_wdata[8*i +: 8];
        else       rd[8*i +: 8] = lmem[8'(lb_addr + i)];
      end
      exp_la   = exp_la + nb(exp_pw);
      lb_rdata <= rd;
      lb_ack   <= 1'b1;
    end else begin
      lb_ack <= 1'b0;
    end
    if (pt_req && !pt_ack) begin
      logic [31:0] rd;
      rd = '0;
      pt_acc++;
      check(pt_addr == exp_ma, "R4 module address", pt_addr, exp_ma);
      check(pt_size == exp_pw, "R4 port size", pt_size, exp_pw);
      check(pt_mem == exp_mem, "R4 port space", pt_mem, exp_mem);
      check(!pt_dack || !exp_mem, "R3 no dack in addressed mode", pt_dack, 0);
      for (int i = 0; i < nb(pt_size); i++) begin
        if (pt_we) pmem[8'(pt_addr + i)] = pt_wdata[8*i +: 8];
        else       rd[8*i +: 8] = pmem[8'(pt_addr + i)];
      end
      exp_ma   = exp_ma + 24'(nb(exp_pw));
      pt_rdata <= rd;
      pt_ack   <= 1'b1;
    end else begin
      pt_ack <= 1'b0;
    end
  end

  task automatic wr_reg(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic wait_idle(input string req);
    int k;
    k = 0;
    while (st_busy && k < 2000) begin
      @(negedge clk);
      k++;
    end
    check(k < 2000, req, k, 0);
  endtask

  task automatic setup(input logic [31:0] la, input logic [23:0] ma, input logic [23:0] cnt,
                       input logic [1:0] pw, input logic mem);
    exp_la = la; exp_ma = ma; exp_pw = pw; exp_mem = mem;
    lb_acc = 0; pt_acc = 0; dack_cnt = 0;
    wr_reg(2'd0, la);
    wr_reg(2'd1, 32'(ma));
    wr_reg(2'd2, 32'(cnt));
  endtask

  task automatic t_reset();
    check(!st_busy && !st_done && !st_err, "R11 status flags", {st_busy, st_done, st_err}, 0);
    check(st_count == 0, "R11 count", st_count, 0);
    check(!lb_req && !pt_req, "R11 buses idle", {lb_req, pt_req}, 0);
  endtask

  task automatic t_addr_to_module_8();
    for (int i = 0; i < 256; i++) begin lmem[i] = 8'(i) ^ 8'h5A; pmem[i] = 8'h00; end
    setup(32'h13, 24'h40, 24'd5, 2'd0, 1'b1);
    pt_dreq = 1'b0;
    wr_reg(2'd3, 32'h3);            // go, addressed, to module, 8-bit
    check(st_busy, "R1 busy after go", st_busy, 1);
    @(negedge clk);
    check(lb_req, "R1 source request without dreq", lb_req, 1);
    wait_idle("R7 completion timeout");
    check(st_done && st_count == 0, "R7 done with zero count", {st_done, st_count}, {1'b1, 24'd0});
    check(lb_acc == 5 && pt_acc == 5, "R4 one access per byte", lb_acc * 100 + pt_acc, 505);
    for (int i = 0; i < 5; i++)
      check(pmem[8'h40 + i] == lmem[8'h13 + i], "R6 local to module data", pmem[8'h40 + i], lmem[8'h13 + i]);
  endtask

  task automatic t_addr_to_local_16();
    for (int i = 0; i < 256; i++) begin pmem[i] = 8'(i * 3 + 1); lmem[i] = 8'h00; end
    setup(32'h81, 24'h10, 24'd6, 2'd1, 1'b1);
    wr_reg(2'd3, 32'hF);            // go, addressed, to local, 16-bit
    wait_idle("R7 completion timeout");
    check(st_done && !st_err, "R7 done flag", {st_done, st_err}, 2'b10);
    check(lb_acc == 3 && pt_acc == 3, "R5 three 16-bit beats", lb_acc * 100 + pt_acc, 303);
    check(lmem[8'h80] == 8'h00 && lmem[8'h87] == 8'h00, "R6 no stray bytes", {lmem[8'h80], lmem[8'h87]}, 0);
    for (int i = 0; i < 6; i++)
      check(lmem[8'h81 + i] == pmem[8'h10 + i], "R6 module to local data", lmem[8'h81 + i], pmem[8'h10 + i]);
  endtask

  task automatic t_illegal();
    setup(32'h0, 24'h0, 24'd3, 2'd1, 1'b1);
    wr_reg(2'd3, 32'hB);            // 16-bit, odd count
    repeat (4) @(negedge clk);
    check(st_err && !st_busy && !st_done, "R8 odd count refused", {st_err, st_busy, st_done}, 3'b100);
    wr_reg(2'd2, 32'd6);
    wr_reg(2'd3, 32'h13);           // 32-bit, count 6
    repeat (4) @(negedge clk);
    check(st_err && !st_busy, "R8 count not multiple of four", {st_err, st_busy}, 2'b10);
    wr_reg(2'd2, 32'd4);
    wr_reg(2'd3, 32'h1B);           // width code 3
    repeat (4) @(negedge clk);
    check(st_err && !st_busy, "R8 width code 3 refused", {st_err, st_busy}, 2'b10);
    wr_reg(2'd2, 32'd0);
    wr_reg(2'd3, 32'h3);            // count zero
    repeat (4) @(negedge clk);
    check(st_err && !st_busy, "R8 zero count refused", {st_err, st_busy}, 2'b10);
    wr_reg(2'd1, 32'd4);
    wr_reg(2'd2, 32'd4);
    pt_dreq = 1'b1;
    wr_reg(2'd3, 32'h11);           // request mode, 32-bit, module address 4
    repeat (4) @(negedge clk);
    check(st_err && !st_busy, "R9 nonzero module address refused", {st_err, st_busy}, 2'b10);
    pt_dreq = 1'b0;
    check(lb_acc == 0 && pt_acc == 0, "R8 no bus activity", lb_acc * 100 + pt_acc, 0);
    check(dack_cnt == 0, "R3 no dack when disabled", dack_cnt, 0);
  endtask

  task automatic t_request_32();
    for (int i = 0; i < 256; i++) begin lmem[i] = 8'(i) ^ 8'hC3; pmem[i] = 8'h00; end
    pt_dreq = 1'b0;
    setup(32'hA2, 24'h0, 24'd8, 2'd2, 1'b0);
    wr_reg(2'd3, 32'h11);           // go, request mode, to module, 32-bit
    check(st_busy && !st_err, "R8 legal go clears error", {st_busy, st_err}, 2'b10);
    repeat (20) @(negedge clk);
    check(lb_acc == 0 && pt_acc == 0, "R2 no transfer without request", lb_acc * 100 + pt_acc, 0);
    check(st_count == 8, "R2 count held", st_count, 8);
    wr_reg(2'd2, 32'h40);
    wr_reg(2'd0, 32'h0);
    check(st_count == 8, "R10 count write ignored while busy", st_count, 8);
    pt_dreq = 1'b1;
    wait_idle("R2 completion timeout");
    check(st_done && st_count == 0, "R7 request mode done", {st_done, st_count}, {1'b1, 24'd0});
    check(dack_cnt == 2, "R3 one dack per port access", dack_cnt, 2);
    check(pt_acc == 2, "R4 two 32-bit accesses", pt_acc, 2);
    for (int i = 0; i < 8; i++)
      check(pmem[i] == lmem[8'hA2 + i], "R6 request mode data", pmem[i], lmem[8'hA2 + i]);
    repeat (10) @(negedge clk);
    check(dack_cnt == 2 && lb_acc == 2, "R3 no dack after finish", dack_cnt, 2);
    pt_dreq = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    n_chk = 0; n_bad = 0;
    exp_la = '0; exp_ma = '0; exp_pw = '0; exp_mem = 1'b0;
    lb_acc = 0; pt_acc = 0; dack_cnt = 0;
    rst_n = 1'b0; reg_wr = 1'b0; reg_sel = '0; reg_wdata = '0;
    pt_dreq = 1'b0; lb_ack = 1'b0; pt_ack = 1'b0; lb_rdata = '0; pt_rdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_addr_to_module_8();
    t_addr_to_local_16();
    t_illegal();
    t_request_32();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule